// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-facing register front end of a serial port. It sits between a simple valid/ready register bus and the port's datapath. It keeps the line configuration and the enable bits that the serialiser, the FIFOs and the line drivers consume. It pushes characters written by software into the transmit FIFO and pops received characters out of the receive FIFO. It also gathers line and FIFO status into one readable word.

Five status flags are sticky: two interrupt-pending flags and three error flags. Software clears each one by writing a one to its bit. A single active-high, level-sensitive interrupt output is raised from the pending flags that have their enable set, and only while the port is enabled. A fill-level field shows either the transmit or the receive FIFO level, so software can poll until the transmitter has drained.

Top module: `sio_regbank`

The four 32-bit registers sit at word offsets 0x000 (control), 0x004 (receive data), 0x008 (transmit data) and 0x00C (status). Address bits above 3 must be zero and bits 1:0 must be zero; any other address is unmapped.

## Requirements
- R1: The control register at 0x000 stores only its defined bits (mask 0x001FD077) and reads back the stored value; the fields go out as data length [1:0], two-stop [2], parity [6:4], flow control enable [12], level select [14], port enable [15], receive DMA enable [16], transmit DMA enable [17], receive interrupt enable [18], transmit interrupt enable [19] and loopback [20]. Reset value is zero.
- R2: A read of 0x004 while the receive FIFO is not empty pops exactly one entry and returns it zero-extended to 32 bits; when the FIFO is empty it returns zero and does not pop.
- R3: A write to 0x008 pushes data bits 7:0 into the transmit FIFO when it is not full; when it is full the write is dropped and status bit 3 (transmit FIFO error) is set.
- R4: Status bit 0 (receive pending) is set while the port is enabled and the receive FIFO is not empty, and status bit 1 (transmit pending) while the port is enabled and the transmit FIFO is not full; neither is set while the port is disabled.
- R5: Writing status with a one in any of bits 4:0 clears that sticky bit, and a zero leaves it unchanged; a set condition in the same cycle wins over the clear.
- R6: A receive overrun event sets status bit 2 and a receive character error event sets status bit 4; both stay set until cleared.
- R7: The interrupt output is high exactly when the port is enabled and (receive pending and its enable) or (transmit pending and its enable) holds.
- R8: Status bit 7 reads the clear-to-send input, but reads one whenever flow control is disabled.
- R9: Status bits 16:11 show the transmit FIFO level when control bit 14 is one and the receive FIFO level when it is zero.
- R10: Status bits 5, 6, 8, 10 and 17 show live receive-empty, transmit-full, request-to-send, transmit-empty and transmitter-busy; the other bits read zero.
- R11: Every accepted request gets a response exactly one cycle later, writes returning zero data; unmapped reads return zero, and unmapped writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after accept |
| rsp_rdata | output | 32 | Response read data |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | CHAR_W | Character pushed to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | CHAR_W | Head of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_level | input | LVL_W | Receive FIFO fill level |
| cts_in | input | 1 | Clear-to-send line state |
| rts_in | input | 1 | Request-to-send line state |
| tx_busy | input | 1 | Transmitter shifting a character |
| rx_overrun_evt | input | 1 | Receive overrun event pulse |
| rx_char_err_evt | input | 1 | Receive parity/framing/break event pulse |
| cfg_data_len | output | 2 | Data length code |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_parity | output | 3 | Parity mode code |
| cfg_flow_en | output | 1 | Automatic flow control enable |
| cfg_enable | output | 1 | Port enable |
| cfg_rx_dma_en | output | 1 | Receive DMA enable |
| cfg_tx_dma_en | output | 1 | Transmit DMA enable |
| cfg_loopback | output | 1 | Internal loopback enable |
| irq | output | 1 | Level interrupt, active high |

## Verification
On every cycle the assertions check the following. The interrupt is never high on a disabled port. A FIFO strobe never fires against a full or empty FIFO. Each accepted request is answered on the next cycle. A pending flag or the transmit error flag never appears without its cause. The bench scenarios are needed for the rest: exact register contents, the write-one-to-clear order against a live set condition, the level-field select, the forced clear-to-send reading and the zero-extended receive data, because each depends on a particular history of writes and side inputs.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int REG_W = 32;

    // word index (address bits 3:2)
    localparam logic [1:0] IDX_CTL  = 2'd0;
    localparam logic [1:0] IDX_RXD  = 2'd1;
    localparam logic [1:0] IDX_TXD  = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;

    // control bit positions
    localparam int C_LEN_LO = 0;
    localparam int C_STOP   = 2;
    localparam int C_PAR_LO = 4;
    localparam int C_FLOW   = 12;
    localparam int C_LVLSEL = 14;
    localparam int C_EN     = 15;
    localparam int C_RXDMA  = 16;
    localparam int C_TXDMA  = 17;
    localparam int C_RXIE   = 18;
    localparam int C_TXIE   = 19;
    localparam int C_LOOP   = 20;
    localparam logic [REG_W-1:0] CTL_MASK = 32'h001F_D077;

    // status bit positions
    localparam int S_RPEND = 0;
    localparam int S_TPEND = 1;
    localparam int S_ROVR  = 2;
    localparam int S_TERR  = 3;
    localparam int S_RCHR  = 4;
    localparam int S_REMP  = 5;
    localparam int S_TFUL  = 6;
    localparam int S_CTS   = 7;
    localparam int S_RTS   = 8;
    localparam int S_TEMP  = 10;
    localparam int S_LVL   = 11;
    localparam int STICKY_N = 5;
endpackage

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctl
);
    typedef struct packed {
        logic [REG_W-1:0] bits;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.bits = wr_data & CTL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ctl = state_q.bits;
endmodule

// File: rtl/sio_sticky_bank.sv
module sio_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] bits;
    } sticky_state_t;

    sticky_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < N; i++) begin
            // a live set condition outranks a clear in the same cycle
            if (set_vec[i])      state_d.bits[i] = 1'b1;
            else if (clr_vec[i]) state_d.bits[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags = state_q.bits;
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              rx_pop,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_empty,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              cts_in,
    input  logic              rts_in,
    input  logic              tx_busy,
    input  logic              rx_overrun_evt,
    input  logic              rx_char_err_evt,
    output logic [1:0]        cfg_data_len,
    output logic              cfg_two_stop,
    output logic [2:0]        cfg_parity,
    output logic              cfg_flow_en,
    output logic              cfg_enable,
    output logic              cfg_rx_dma_en,
    output logic              cfg_tx_dma_en,
    output logic              cfg_loopback,
    output logic              irq
);
    localparam int LVL_MSB  = S_LVL + LVL_W - 1;
    localparam int BUSY_POS = S_LVL + LVL_W;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] rdata;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;

    logic [REG_W-1:0]    ctl_q;
    logic [STICKY_N-1:0] sticky_q;
    logic [STICKY_N-1:0] sticky_set;
    logic [STICKY_N-1:0] sticky_clr;
    logic [REG_W-1:0]    stat_word;
    logic                addr_hit;
    logic [1:0]          word_idx;
    logic                sel_ctl, sel_rxd, sel_txd, sel_stat;
    logic                tx_drop;

    assign req_ready = 1'b1;
    assign word_idx  = req_addr[3:2];
    assign addr_hit  = (req_addr[ADDR_W-1:4] == '0) && (req_addr[1:0] == 2'b00);
    assign sel_ctl   = req_valid && addr_hit && (word_idx == IDX_CTL);
    assign sel_rxd   = req_valid && addr_hit && (word_idx == IDX_RXD);
    assign sel_txd   = req_valid && addr_hit && (word_idx == IDX_TXD);
    assign sel_stat  = req_valid && addr_hit && (word_idx == IDX_STAT);

    assign rx_pop  = sel_rxd && !req_write && !rx_empty;
    assign tx_push = sel_txd && req_write && !tx_full;
    assign tx_drop = sel_txd && req_write && tx_full;
    assign tx_data = req_wdata[CHAR_W-1:0];

    sio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_ctl && req_write),
        .wr_data (req_wdata),
        .ctl     (ctl_q)
    );

    assign cfg_data_len  = ctl_q[C_LEN_LO +: 2];
    assign cfg_two_stop  = ctl_q[C_STOP];
    assign cfg_parity    = ctl_q[C_PAR_LO +: 3];
    assign cfg_flow_en   = ctl_q[C_FLOW];
    assign cfg_enable    = ctl_q[C_EN];
    assign cfg_rx_dma_en = ctl_q[C_RXDMA];
    assign cfg_tx_dma_en = ctl_q[C_TXDMA];
    assign cfg_loopback  = ctl_q[C_LOOP];

    always_comb begin
        sticky_set          = '0;
        sticky_set[S_RPEND] = ctl_q[C_EN] && !rx_empty;
        sticky_set[S_TPEND] = ctl_q[C_EN] && !tx_full;
        sticky_set[S_ROVR]  = rx_overrun_evt;
        sticky_set[S_TERR]  = tx_drop;
        sticky_set[S_RCHR]  = rx_char_err_evt;
        sticky_clr          = (sel_stat && req_write) ? req_wdata[STICKY_N-1:0] : '0;
    end

    sio_sticky_bank #(.N(STICKY_N)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (sticky_set),
        .clr_vec (sticky_clr),
        .flags   (sticky_q)
    );

    assign irq = ctl_q[C_EN] &&
                 ((sticky_q[S_RPEND] && ctl_q[C_RXIE]) ||
                  (sticky_q[S_TPEND] && ctl_q[C_TXIE]));

    always_comb begin
        stat_word                   = '0;
        stat_word[STICKY_N-1:0]     = sticky_q;
        stat_word[S_REMP]           = rx_empty;
        stat_word[S_TFUL]           = tx_full;
        stat_word[S_CTS]            = cts_in || !ctl_q[C_FLOW];
        stat_word[S_RTS]            = rts_in;
        stat_word[S_TEMP]           = tx_empty;
        stat_word[LVL_MSB:S_LVL]    = ctl_q[C_LVLSEL] ? tx_level : rx_level;
        stat_word[BUSY_POS]         = tx_busy;
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (!req_write) begin
            if (sel_ctl)       rsp_d.rdata = ctl_q;
            else if (sel_stat) rsp_d.rdata = stat_word;
            else if (rx_pop)   rsp_d.rdata = {{(REG_W-CHAR_W){1'b0}}, rx_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              tx_push,
    input logic              tx_full,
    input logic              rx_pop,
    input logic              rx_empty,
    input logic              cfg_enable,
    input logic              irq,
    input logic [4:0]        sticky
);
    logic txd_write;
    assign txd_write = req_valid && req_write && (req_addr == ADDR_W'('h8));

    // R7: no interrupt from a disabled port
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_enable);

    // R3: never push into a full transmit FIFO
    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    // R2: never pop an empty receive FIFO, never on a write
    assert_no_pop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (!rx_empty && !req_write));

    // R11: one response per accepted request, one cycle later
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: pending flags cannot appear on a disabled port
    assert_rx_pend_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !sticky[0]) |=> !sticky[0]);
    assert_tx_pend_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !sticky[1]) |=> !sticky[1]);

    // R3: transmit error only from a transmit-data write against a full FIFO
    assert_terr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky[3] && !(txd_write && tx_full)) |=> !sticky[3]);
endmodule

bind sio_regbank sio_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .tx_push    (tx_push),
    .tx_full    (tx_full),
    .rx_pop     (rx_pop),
    .rx_empty   (rx_empty),
    .cfg_enable (cfg_enable),
    .irq        (irq),
    .sticky     (sticky_q)
);

// File: tb/sio_regbank_tb_top.sv
module sio_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        tx_push, rx_pop;
    logic [7:0]  tx_data;
    logic        tx_full = 1'b0, tx_empty = 1'b1;
    logic [5:0]  tx_level = '0, rx_level = '0;
    logic [7:0]  rx_data = '0;
    logic        rx_empty = 1'b1;
    logic        cts_in = 1'b0, rts_in = 1'b0, tx_busy = 1'b0;
    logic        rx_overrun_evt = 1'b0, rx_char_err_evt = 1'b0;
    logic [1:0]  cfg_data_len;
    logic [2:0]  cfg_parity;
    logic        cfg_two_stop, cfg_flow_en, cfg_enable;
    logic        cfg_rx_dma_en, cfg_tx_dma_en, cfg_loopback, irq;

    int checks = 0, errors = 0;
    int push_cnt = 0, pop_cnt = 0;
    logic [7:0] last_tx = '0;
    bit   done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sio_regbank dut_i (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: issues one transaction and queues its expected response
    task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each response against the scoreboard queue
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (tx_push) begin push_cnt++; last_tx = tx_data; end
        if (rx_pop) pop_cnt++;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check({31'b0, irq}, 0, "R7 irq after reset");
        check({31'b0, rsp_valid}, 0, "R11 no response after reset");
        bus(0, 12'h000, 0, 32'h0, "R1 control reset value");
        // disabled: no pending, live bits, cts forced with flow off
        bus(0, 12'h00C, 0, 32'h0000_04A0, "R4/R8/R10 status after reset");

        // R1: mask and field outputs
        bus(1, 12'h000, 32'hFFFF_FFFF, 0, "R11 write response");
        bus(0, 12'h000, 0, 32'h001F_D077, "R1 control masked readback");
        check({30'b0, cfg_data_len}, 3, "R1 data length");
        check({29'b0, cfg_parity}, 7, "R1 parity");
        check({24'b0, cfg_two_stop, cfg_flow_en, cfg_enable, cfg_rx_dma_en,
               cfg_tx_dma_en, cfg_loopback, 2'b0}, 32'h0000_00FC, "R1 enables");
        rx_level = 6'd5; tx_level = 6'd9;
        idle(2);
        check({31'b0, irq}, 1, "R7 irq from tx pending");
        // tx level selected, cts 0 with flow on
        bus(0, 12'h00C, 0, 32'h0000_4C22, "R8/R9 status tx level");

        // enable + rx irq enable, rx level, flow off
        bus(1, 12'h000, 32'h0004_8000, 0, "R1 write");
        bus(0, 12'h00C, 0, 32'h0000_2CA2, "R9/R8 status rx level");
        check({31'b0, irq}, 0, "R7 tx pending without enable");

        // R5: write zero keeps, write one clears
        tx_full = 1'b1; tx_empty = 1'b0;
        bus(1, 12'h00C, 32'h0, 0, "R5 write zero");
        bus(0, 12'h00C, 0, 32'h0000_28E2, "R5 zero leaves tip");
        bus(1, 12'h00C, 32'h2, 0, "R5 clear tip");
        bus(0, 12'h00C, 0, 32'h0000_28E0, "R5 tip cleared");

        // R3: dropped write when full
        pc = push_cnt;
        bus(1, 12'h008, 32'h0000_01A5, 0, "R3 write full");
        check(push_cnt, pc, "R3 no push when full");
        bus(0, 12'h00C, 0, 32'h0000_28E8, "R3 tx error flag");
        tx_full = 1'b0;
        bus(1, 12'h008, 32'h0000_013C, 0, "R3 write");
        check(push_cnt, pc + 1, "R3 one push");
        check({24'b0, last_tx}, 32'h3C, "R3 pushed data");
        // R5: set wins over clear while tx not full
        bus(1, 12'h00C, 32'h2, 0, "R5 clear during set");
        bus(0, 12'h00C, 0, 32'h0000_28AA, "R5 set wins");

        // R2: receive data and pending
        rx_data = 8'hC3; rx_empty = 1'b0;
        idle(2);
        check({31'b0, irq}, 1, "R7 irq from rx pending");
        pc = pop_cnt;
        bus(0, 12'h004, 0, 32'h0000_00C3, "R2 rx data zero-extended");
        check(pop_cnt, pc + 1, "R2 one pop");
        rx_empty = 1'b1;
        bus(0, 12'h004, 0, 32'h0, "R2 empty read zero");
        check(pop_cnt, pc + 1, "R2 no pop when empty");
        bus(1, 12'h00C, 32'h1, 0, "R5 clear rip");
        idle(1);
        check({31'b0, irq}, 0, "R7 irq drops after clear");

        // R6 error events, R10 live bits
        rts_in = 1'b1; tx_busy = 1'b1;
        @(negedge clk); rx_overrun_evt = 1'b1; rx_char_err_evt = 1'b1;
        @(negedge clk); rx_overrun_evt = 1'b0; rx_char_err_evt = 1'b0;
        idle(2);
        bus(0, 12'h00C, 0, 32'h0002_29BE, "R6/R10 error flags and live bits");
        bus(1, 12'h00C, 32'h1C, 0, "R5 clear errors");
        bus(0, 12'h00C, 0, 32'h0002_29A2, "R5/R6 errors cleared");

        // R11 unmapped
        bus(0, 12'h010, 0, 32'h0, "R11 unmapped read");
        bus(1, 12'h010, 32'hFFFF_FFFF, 0, "R11 unmapped write");
        bus(0, 12'h000, 0, 32'h0004_8000, "R11 unmapped write ignored");
        bus(0, 12'h008, 0, 32'h0, "R11 tx data reads zero");

        // R4: disabled port does not raise pending
        bus(1, 12'h000, 32'h0, 0, "R4 disable");
        bus(1, 12'h00C, 32'h3, 0, "R4 clear pending");
        rx_empty = 1'b0;
        idle(3);
        bus(0, 12'h00C, 0, 32'h0002_2980, "R4 no pending while disabled");
        check({31'b0, irq}, 0, "R7 irq off while disabled");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule